// File: doc/BRIEF.md
# Recirculating Serial Shift Register

This block is a serial-in, serial-out delay line of configurable length, 64 stages by default. On every rising clock edge one bit enters the first stage and every stored bit moves one place toward the end. The last stage drives the main serial output. A select input picks the bit that enters. When it is low, the bit comes from the primary data input. When it is high, the bit comes from a second serial input. Feeding the main output back into that second input makes the stored word circulate without loss. With the inputs driven from two independent sources, the select input works as a per-edge multiplexer between two bit streams.

Two extra outputs help when several instances are chained. A half-stage output latches the main output on the falling edge, so it trails the main output by half a period. A delayed clock output repeats the input clock so that the next instance can be clocked from it. Every element is edge-triggered and static. The contents therefore stay unchanged for as long as the clock rests at either level.

Top module: `recirc_shift_reg`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every stage clears to 0 and `q_out` is 0 after that edge. While `rst_n` is low at a falling edge, `q_half` clears to 0.
- R2: At each rising edge with `rst_n` high, stage 1 loads the selected serial bit and stage k loads the old value of stage k-1. As a result, `q_out` shows the bit that was selected DEPTH rising edges earlier.
- R3: When `mode_sel` is 1 at a rising edge, the bit that enters stage 1 is `din_loop`, and `din` has no effect.
- R4: When `mode_sel` is 0 at a rising edge, the bit that enters stage 1 is `din`, and `din_loop` has no effect.
- R5: At each falling edge, `q_half` takes the value that `q_out` holds at that moment. It keeps that value until the next falling edge.
- R6: While the clock rests high or rests low, `q_out` and `q_half` keep their values, whatever `din`, `din_loop` and `mode_sel` do.
- R7: `clk_dly` has the same level as `clk` at all sample points in both clock phases.
- R8: If `din_loop` is fed from `q_out` and `mode_sel` is held at 1, the bit sequence seen at `q_out` repeats with a period of exactly DEPTH rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; the stages update on the rising edge |
| rst_n | input | 1 | Active-low synchronous clear |
| mode_sel | input | 1 | Source select for stage 1: 0 picks din, 1 picks din_loop |
| din | input | 1 | Primary serial data input |
| din_loop | input | 1 | Second serial input, used for recirculation |
| q_out | output | 1 | Last stage output |
| q_half | output | 1 | Last stage value latched on the falling edge |
| clk_dly | output | 1 | Buffered copy of clk for the next instance in a chain |

## Verification
On every rising edge, the assertions check the move of each bit from one stage to the next, the source that stage 1 takes under each select value, and the agreement between the half stage and the last stage. Three behaviours rest on the bench scenarios alone. The first is the exact DEPTH-edge delay of a pseudo-random stream, checked against a queue model. The second is the repeat of a known word after a full circulation. The third is that the contents hold while the clock is parked high or low and all inputs are toggled.

// File: rtl/rsr_pkg.sv
package rsr_pkg;

   typedef enum logic {
      SRC_PRIMARY = 1'b0,
      SRC_LOOP    = 1'b1
   } src_sel_e;

   function automatic logic pick_src(input src_sel_e sel, input logic primary, input logic loopback);
      return (sel == SRC_LOOP) ? loopback : primary;
   endfunction

endpackage

// File: rtl/rsr_src_mux.sv
module rsr_src_mux
   import rsr_pkg::*;
(
   input  logic mode_sel,
   input  logic primary_bit,
   input  logic loop_bit,
   output logic serial_bit
);

   src_sel_e sel;

   always_comb begin
      sel        = src_sel_e'(mode_sel);
      serial_bit = pick_src(sel, primary_bit, loop_bit);
   end

endmodule

// File: rtl/rsr_chain.sv
module rsr_chain #(
   parameter int DEPTH = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic serial_in,
   output logic head,
   output logic tail
);

   localparam int LAST = DEPTH - 1;

   logic [LAST:0] stg;

   always_ff @(posedge clk) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[LAST-1:0], serial_in};
   end

   assign head = stg[0];
   assign tail = stg[LAST];

   // R2: the first stage captures the serial input of the previous edge
   assert_head_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> stg[0] == $past(serial_in));

   // R2: each later stage takes the previous contents of its neighbour
   for (genvar k = 1; k <= LAST; k++) begin : g_hop
      assert_stage_hop_R2: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> stg[k] == $past(stg[k-1]));
   end

endmodule

// File: rtl/rsr_half_stage.sv
module rsr_half_stage (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   always_ff @(negedge clk) begin
      if (!rst_n) q <= 1'b0;
      else        q <= d;
   end

   // R5: between rising edges the half stage matches the last full stage
   assert_half_track_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> q == d);

endmodule

// File: rtl/rsr_clk_buf.sv
module rsr_clk_buf (
   input  logic clk_in,
   output logic clk_out
);

   assign clk_out = clk_in;

endmodule

// File: rtl/recirc_shift_reg.sv
module recirc_shift_reg #(
   parameter int DEPTH = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mode_sel,
   input  logic din,
   input  logic din_loop,
   output logic q_out,
   output logic q_half,
   output logic clk_dly
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("recirc_shift_reg: DEPTH must be at least 2");
   end

   logic serial_bit;
   logic first_stage;

   rsr_src_mux u_mux (
      .mode_sel   (mode_sel),
      .primary_bit(din),
      .loop_bit   (din_loop),
      .serial_bit (serial_bit)
   );

   rsr_chain #(.DEPTH(DEPTH)) u_chain (
      .clk      (clk),
      .rst_n    (rst_n),
      .serial_in(serial_bit),
      .head     (first_stage),
      .tail     (q_out)
   );

   rsr_half_stage u_half (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (q_out),
      .q    (q_half)
   );

   rsr_clk_buf u_cbuf (
      .clk_in (clk),
      .clk_out(clk_dly)
   );

   // R3: select high routes the loop input into stage 1
   assert_loop_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(mode_sel)) |-> first_stage == $past(din_loop));

   // R4: select low routes the primary input into stage 1
   assert_primary_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(mode_sel)) |-> first_stage == $past(din));

endmodule

// File: tb/recirc_shift_reg_tb.sv
`timescale 1ns/1ps
module recirc_shift_reg_tb;

   localparam int DEPTH = 64;
   localparam logic [63:0] PATTERN = 64'hA5C3_0F96_1E2D_7B48;

   logic clk = 1'b0;
   logic clk_run = 1'b1;
   logic rst_n = 1'b0;
   logic mode_sel = 1'b0;
   logic din = 1'b0;
   logic din_loop = 1'b0;
   logic q_out, q_half, clk_dly;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   logic [DEPTH-1:0] mdl = '0;
   logic [15:0] lfsr = 16'hACE1;
   logic [DEPTH-1:0] seq_a, seq_b;

   recirc_shift_reg #(.DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .din(din),
      .din_loop(din_loop), .q_out(q_out), .q_half(q_half), .clk_dly(clk_dly)
   );

   always #4 if (clk_run) clk = ~clk;

   task automatic chk(input logic act, input logic exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic mdl_edge();
      if (!rst_n) mdl = '0;
      else        mdl = {mdl[DEPTH-2:0], (mode_sel ? din_loop : din)};
   endtask

   task automatic tick(input logic m, input logic d, input logic l, input string tag);
      mode_sel = m; din = d; din_loop = l;
      @(posedge clk);
      mdl_edge();
      #2;
      chk(q_out, mdl[DEPTH-1], tag);
      chk(clk_dly, 1'b1, "R7 high phase");
      @(negedge clk);
      #1;
      chk(q_half, mdl[DEPTH-1], "R5 half stage");
      chk(clk_dly, 1'b0, "R7 low phase");
   endtask

   function automatic logic lfsr_bit();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      return lfsr[0];
   endfunction

   task automatic park(input logic high);
      logic hold_q, hold_h;
      if (high) begin
         @(posedge clk);
         mdl_edge();
         #1 clk_run = 1'b0;
      end else begin
         clk_run = 1'b0;
      end
      hold_q = q_out;
      hold_h = q_half;
      chk(q_out, mdl[DEPTH-1], "R6 parked value");
      for (int i = 0; i < 10; i++) begin
         #20;
         din = ~din; din_loop = ~din_loop; mode_sel = ~mode_sel;
         #1;
         chk(q_out, hold_q, "R6 q_out held");
         chk(q_half, hold_h, "R6 q_half held");
         chk(clk_dly, high, "R7 parked level");
      end
      clk_run = 1'b1;
      if (high) begin
         @(negedge clk);
         #1;
         chk(q_half, mdl[DEPTH-1], "R5 after high park");
      end
   endtask

   initial begin
      // R1: reset clears everything even with ones on the inputs
      for (int i = 0; i < 4; i++) tick(1'b0, 1'b1, 1'b1, "R1 reset clear");
      chk(q_half, 1'b0, "R1 half stage clear");
      #2 rst_n = 1'b1;

      // R2 and R4: pseudo-random stream on din, opposite noise on din_loop
      for (int i = 0; i < 3 * DEPTH; i++) begin
         logic b;
         b = lfsr_bit();
         tick(1'b0, b, ~b, "R2 R4 primary stream");
      end

      // R3: stream on din_loop, din forced to a constant that must be ignored
      for (int i = 0; i < 2 * DEPTH; i++) tick(1'b1, 1'b1, lfsr_bit(), "R3 loop stream");

      // R3 and R4: select toggles every edge between two fixed sources
      for (int i = 0; i < 2 * DEPTH; i++) tick(i[0], 1'b1, 1'b0, "R3 R4 interleave");

      // R6: hold with the clock parked high and then parked low
      park(1'b1);
      tick(1'b0, 1'b1, 1'b0, "R2 after park");
      park(1'b0);
      tick(1'b0, 1'b0, 1'b1, "R2 after low park");

      // R8: load a known word, then circulate it twice
      for (int k = 0; k < DEPTH; k++) tick(1'b0, PATTERN[63-k], 1'b0, "R8 load");
      for (int j = 0; j < DEPTH; j++) begin
         tick(1'b1, ~q_out, q_out, "R8 first lap");
         seq_a[j] = q_out;
      end
      for (int j = 0; j < DEPTH; j++) begin
         tick(1'b1, ~q_out, q_out, "R8 second lap");
         seq_b[j] = q_out;
      end
      for (int j = 0; j < DEPTH; j++) begin
         chk(seq_a[j], PATTERN[(62 - j + 64) % 64], "R8 lap matches word");
         chk(seq_b[j], seq_a[j], "R8 lap repeats");
      end

      // R1: reset in mid-stream clears a loaded register
      rst_n = 1'b0;
      tick(1'b0, 1'b1, 1'b1, "R1 mid-stream reset");
      chk(q_half, 1'b0, "R1 mid-stream half clear");
      rst_n = 1'b1;

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule